// File: doc/BRIEF.md
# Multithreaded Commit Thread Selector

This block decides which hardware thread is allowed to retire the instruction at the head of its reorder buffer in the next commit slot. Each thread reports four things: a commit status, an empty flag for its buffer, a head-ready flag, and the sequence number of its head instruction. A static policy input chooses how the block arbitrates among the threads. The outputs are a valid flag and the index of the chosen thread.

The selection is combinational from the current inputs. Under the round-robin policy, a registered priority order rotates when the consumer takes a selection. The consumer raises `sel_take` in any cycle where it uses the offered thread. Successive slots are served in successive cycles, and each one sees the order as updated by the previous take.

Under the oldest-ready policy, the block compares head sequence numbers and chooses the thread with the oldest head. This makes it suitable for commit logic that calls the selector repeatedly within one retirement window. When only one thread is configured, all arbitration is dropped and a simple status gate remains.

Top module: `commit_thread_sel`

## Requirements
- R1: `policy` encoding is 0 = aggressive, 1 = round-robin, 2 = oldest-ready and 3 = oldest-ready. Aggressive chooses exactly as oldest-ready does.
- R2: After reset the round-robin order is thread 0, 1, 2, 3 (ascending index). The order is always a permutation of all thread indices.
- R3: In round-robin mode a thread is eligible when its status is Running (0) or Idle (1) and its head-ready bit is set. The selector returns the eligible thread that comes first in the current order.
- R4: On a rising clock edge with round-robin mode, `sel_take` high and `sel_valid` high, the chosen thread moves to the back of the order. The threads behind it each move one place forward.
- R5: The order is unchanged on any edge where `sel_take` is low, where `sel_valid` is low, or where the policy is not round-robin.
- R6: In oldest-ready mode a thread is eligible when its buffer is not empty, its head is ready, and its status is Running (0), Idle (1) or FetchTrapPending (4). Status RobSquashing (2) and TrapPending (3) never qualify in either mode. FetchTrapPending does not qualify for round-robin.
- R7: In oldest-ready mode the selector returns the eligible thread with the smallest head sequence number, compared as unsigned. On equal sequence numbers the lower thread index wins.
- R8: When no thread qualifies, `sel_valid` is 0 and `sel_tid` is 0.
- R9: With `NUM_THREADS` = 1, `sel_valid` equals "status of thread 0 is Running, Idle or FetchTrapPending". This holds regardless of policy, ready and empty inputs, and `sel_tid` is 0.
- R10: `sel_valid` and `sel_tid` respond to input changes within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 2 | Arbitration policy (R1 encoding) |
| thr_status | input | 3*NUM_THREADS | Per-thread commit status, thread i at bits [3i+2:3i] |
| thr_empty | input | NUM_THREADS | Per-thread reorder buffer empty flag |
| thr_ready | input | NUM_THREADS | Per-thread head-ready flag |
| thr_seq | input | SEQ_W*NUM_THREADS | Per-thread head sequence number |
| sel_take | input | 1 | Consumer used the offered thread this cycle |
| sel_valid | output | 1 | A thread is selected |
| sel_tid | output | TID_W | Selected thread index |

## Verification
The bench targets the round-robin rotation. A design that rotated on every edge, or rotated when not taken, would break the expected pick sequence on the following cycles. A design that reinserted the chosen thread at the wrong place would also break that sequence. Ties in sequence number are forced often by drawing sequence numbers from a small range, so a scan that lets the higher index win shows up quickly. The bench also places FetchTrapPending threads and non-ready or empty threads in front of eligible ones, so a mixed-up eligibility rule would pick the wrong thread or report a false selection.

// File: rtl/cts_pkg.sv
package cts_pkg;
  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_IDLE   = 3'd1,
    ST_SQUASH = 3'd2,
    ST_TRAP   = 3'd3,
    ST_FTRAP  = 3'd4
  } thr_state_e;

  typedef enum logic [1:0] {
    POL_AGGR   = 2'd0,
    POL_RR     = 2'd1,
    POL_OLDEST = 2'd2,
    POL_ALT    = 2'd3
  } pol_e;

  localparam int ST_W = 3;

  function automatic logic rr_status_ok(input logic [ST_W-1:0] st);
    return (st == ST_RUN) || (st == ST_IDLE);
  endfunction

  function automatic logic old_status_ok(input logic [ST_W-1:0] st);
    return (st == ST_RUN) || (st == ST_IDLE) || (st == ST_FTRAP);
  endfunction
endpackage

// File: rtl/cts_rr_order.sv
module cts_rr_order #(
  parameter int NT = 4,
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] elig,
  input  logic          advance,
  output logic          hit,
  output logic [TW-1:0] hit_tid
);
  logic [NT-1:0][TW-1:0] order_q, order_d;
  logic [TW-1:0]         hit_pos;
  logic                  upd_en;

  always_comb begin
    hit     = 1'b0;
    hit_pos = '0;
    hit_tid = '0;
    for (int p = 0; p < NT; p++) begin
      if (!hit && elig[order_q[p]]) begin
        hit     = 1'b1;
        hit_pos = TW'(p);
        hit_tid = order_q[p];
      end
    end
  end

  assign upd_en = advance && hit;

  always_comb begin
    order_d = order_q;
    for (int p = 0; p < NT; p++) begin
      if (p == NT - 1)
        order_d[p] = hit_tid;
      else if (TW'(p) >= hit_pos)
        order_d[p] = order_q[p+1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NT; p++) order_q[p] <= TW'(p);
    end else if (upd_en) begin
      order_q <= order_d;
    end
  end

  logic [NT-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < NT; p++) seen[order_q[p]] = 1'b1;
  end

  assert_order_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seen == {NT{1'b1}});
  assert_hit_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> elig[hit_tid]);
  assert_moved_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && hit) |=> order_q[NT-1] == $past(hit_tid));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && hit) |=> $stable(order_q));
endmodule

// File: rtl/cts_oldest_pick.sv
module cts_oldest_pick #(
  parameter int NT = 4,
  parameter int TW = 2,
  parameter int SW = 16
) (
  input  logic [NT-1:0]         elig,
  input  logic [NT-1:0][SW-1:0] seq,
  output logic                  hit,
  output logic [TW-1:0]         hit_tid
);
  logic [SW-1:0] best_seq;

  always_comb begin
    hit      = 1'b0;
    hit_tid  = '0;
    best_seq = '0;
    for (int t = 0; t < NT; t++) begin
      if (elig[t] && (!hit || seq[t] < best_seq)) begin
        hit      = 1'b1;
        hit_tid  = TW'(t);
        best_seq = seq[t];
      end
    end
  end
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel #(
  parameter int NUM_THREADS = 4,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [1:0]                     policy,
  input  logic [3*NUM_THREADS-1:0]       thr_status,
  input  logic [NUM_THREADS-1:0]         thr_empty,
  input  logic [NUM_THREADS-1:0]         thr_ready,
  input  logic [SEQ_W*NUM_THREADS-1:0]   thr_seq,
  input  logic                           sel_take,
  output logic                           sel_valid,
  output logic [TID_W-1:0]               sel_tid
);
  import cts_pkg::*;

  localparam int NT = NUM_THREADS;

  logic [NT-1:0][ST_W-1:0]  st_arr;
  logic [NT-1:0][SEQ_W-1:0] seq_arr;
  logic [NT-1:0]            rr_elig, old_elig;
  logic                     rr_mode;

  assign st_arr  = thr_status;
  assign seq_arr = thr_seq;
  assign rr_mode = (pol_e'(policy) == POL_RR);

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      rr_elig[t]  = rr_status_ok(st_arr[t]) && thr_ready[t];
      old_elig[t] = old_status_ok(st_arr[t]) && thr_ready[t] && !thr_empty[t];
    end
  end

  generate
    if (NT == 1) begin : g_single
      assign sel_valid = old_status_ok(st_arr[0]);
      assign sel_tid   = '0;

      assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid == ((thr_status[2:0] == 3'd0) || (thr_status[2:0] == 3'd1) ||
                      (thr_status[2:0] == 3'd4)));
    end else begin : g_multi
      logic             rr_hit, old_hit;
      logic [TID_W-1:0] rr_tid, old_tid;

      cts_rr_order #(.NT(NT), .TW(TID_W)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (rr_elig),
        .advance (rr_mode && sel_take),
        .hit     (rr_hit),
        .hit_tid (rr_tid)
      );

      cts_oldest_pick #(.NT(NT), .TW(TID_W), .SW(SEQ_W)) u_old (
        .elig    (old_elig),
        .seq     (seq_arr),
        .hit     (old_hit),
        .hit_tid (old_tid)
      );

      always_comb begin
        if (rr_mode) begin
          sel_valid = rr_hit;
          sel_tid   = rr_hit ? rr_tid : '0;
        end else begin
          sel_valid = old_hit;
          sel_tid   = old_hit ? old_tid : '0;
        end
      end

      logic older_exists;
      always_comb begin
        older_exists = 1'b0;
        for (int t = 0; t < NT; t++) begin
          if (old_elig[t] && (seq_arr[t] < seq_arr[sel_tid] ||
              (seq_arr[t] == seq_arr[sel_tid] && TID_W'(t) < sel_tid)))
            older_exists = 1'b1;
        end
      end

      assert_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !rr_mode) |-> !older_exists);
      assert_old_elig_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !rr_mode) |-> old_elig[sel_tid]);
      assert_none_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> sel_tid == '0);
      assert_anyvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid == (rr_mode ? (|rr_elig) : (|old_elig)));
    end
  endgenerate
endmodule

// File: tb/tb_commit_thread_sel.sv
module tb_commit_thread_sel;
  localparam int NT = 4;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    policy;
  logic [3*NT-1:0] thr_status;
  logic [NT-1:0] thr_empty, thr_ready;
  logic [SW*NT-1:0] thr_seq;
  logic          sel_take;
  logic          sel_valid;
  logic [1:0]    sel_tid;

  logic [2:0]    s1_status;
  logic          s1_empty, s1_ready, s1_take, s1_valid;
  logic [SW-1:0] s1_seq;
  logic          s1_tid;

  always #2.5 clk = ~clk;

  commit_thread_sel #(.NUM_THREADS(NT), .SEQ_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_status(thr_status),
    .thr_empty(thr_empty), .thr_ready(thr_ready), .thr_seq(thr_seq),
    .sel_take(sel_take), .sel_valid(sel_valid), .sel_tid(sel_tid));

  commit_thread_sel #(.NUM_THREADS(1), .SEQ_W(SW)) dut1 (
    .clk(clk), .rst_n(rst_n), .policy(policy), .thr_status(s1_status),
    .thr_empty(s1_empty), .thr_ready(s1_ready), .thr_seq(s1_seq),
    .sel_take(s1_take), .sel_valid(s1_valid), .sel_tid(s1_tid));

  int n_tests = 0;
  int n_fail  = 0;
  int ord [NT];

  function automatic logic [2:0] st_of(int t);
    return thr_status[3*t +: 3];
  endfunction

  function automatic logic [SW-1:0] seq_of(int t);
    return thr_seq[SW*t +: SW];
  endfunction

  task automatic expect_sel(output logic v, output int tid);
    v = 1'b0; tid = 0;
    if (policy == 2'd1) begin
      for (int p = 0; p < NT; p++) begin
        int t = ord[p];
        if (!v && (st_of(t) == 3'd0 || st_of(t) == 3'd1) && thr_ready[t]) begin
          v = 1'b1; tid = t;
        end
      end
    end else begin
      for (int t = 0; t < NT; t++) begin
        if ((st_of(t) == 3'd0 || st_of(t) == 3'd1 || st_of(t) == 3'd4) &&
            thr_ready[t] && !thr_empty[t] && (!v || seq_of(t) < seq_of(tid))) begin
          v = 1'b1; tid = t;
        end
      end
    end
  endtask

  task automatic check(string req, logic v, int tid);
    n_tests++;
    if (sel_valid !== v || int'(sel_tid) != tid) begin
      n_fail++;
      $display("FAIL %s: valid/tid actual %0b/%0d expected %0b/%0d",
               req, sel_valid, sel_tid, v, tid);
    end
  endtask

  task automatic apply(string req, logic [1:0] pol, logic [3*NT-1:0] st,
                       logic [NT-1:0] emp, logic [NT-1:0] rdy,
                       logic [SW*NT-1:0] sq, logic take);
    logic ev; int et;
    @(negedge clk);
    policy = pol; thr_status = st; thr_empty = emp; thr_ready = rdy;
    thr_seq = sq; sel_take = take;
    #1;
    expect_sel(ev, et);
    check(req, ev, et);
    if (pol == 2'd1 && take && ev) begin
      int pos = 0;
      for (int p = 0; p < NT; p++) if (ord[p] == et) pos = p;
      for (int p = pos; p < NT - 1; p++) ord[p] = ord[p+1];
      ord[NT-1] = et;
    end
  endtask

  task automatic check1(string req, logic [2:0] st, logic rdy, logic emp);
    logic ev;
    @(negedge clk);
    s1_status = st; s1_ready = rdy; s1_empty = emp;
    #1;
    ev = (st == 3'd0 || st == 3'd1 || st == 3'd4);
    n_tests++;
    if (s1_valid !== ev || s1_tid !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: valid/tid actual %0b/%0d expected %0b/0",
               req, s1_valid, s1_tid, ev);
    end
  endtask

  localparam logic [11:0] ALL_RUN = 12'h000;

  initial begin : watchdog
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    rst_n = 1'b0; policy = 2'd1; thr_status = '0; thr_empty = '0;
    thr_ready = '0; thr_seq = '0; sel_take = 1'b0;
    s1_status = 3'd2; s1_empty = 1'b1; s1_ready = 1'b0; s1_take = 1'b0; s1_seq = '0;
    for (int p = 0; p < NT; p++) ord[p] = p;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 reset order, R4 rotation on take
    apply("R2", 2'd1, ALL_RUN, 4'h0, 4'hF, '0, 1'b1);
    apply("R4", 2'd1, ALL_RUN, 4'h0, 4'hF, '0, 1'b1);
    apply("R4", 2'd1, ALL_RUN, 4'h0, 4'hF, '0, 1'b1);
    apply("R4", 2'd1, ALL_RUN, 4'h0, 4'hF, '0, 1'b1);
    apply("R4", 2'd1, ALL_RUN, 4'h0, 4'hF, '0, 1'b0);
    // R5 hold without take, with oldest policy, with no valid
    apply("R5", 2'd1, ALL_RUN, 4'h0, 4'hF, '0, 1'b0);
    apply("R5", 2'd2, ALL_RUN, 4'h0, 4'hF, '0, 1'b1);
    apply("R5", 2'd1, ALL_RUN, 4'h0, 4'h0, '0, 1'b1);
    apply("R5", 2'd1, ALL_RUN, 4'h0, 4'hF, '0, 1'b0);
    // R3/R6 FetchTrapPending at front is skipped by round-robin
    apply("R6", 2'd1, {3'd0, 3'd0, 3'd4, 3'd4}, 4'h0, 4'hF, '0, 1'b1);
    apply("R3", 2'd1, {3'd1, 3'd2, 3'd3, 3'd0}, 4'h0, 4'hD, '0, 1'b1);
    // R6 FetchTrapPending qualifies for oldest; empty excluded
    apply("R6", 2'd2, {3'd2, 3'd3, 3'd0, 3'd4}, 4'h2, 4'hF,
          {8'd1, 8'd1, 8'd9, 8'd7}, 1'b0);
    // R7 tie goes to lower index; R1 aggressive equals oldest
    apply("R7", 2'd2, ALL_RUN, 4'h0, 4'hF, {8'd3, 8'd5, 8'd3, 8'd4}, 1'b0);
    apply("R1", 2'd0, ALL_RUN, 4'h0, 4'hF, {8'd2, 8'd5, 8'd3, 8'd4}, 1'b0);
    apply("R1", 2'd3, ALL_RUN, 4'h1, 4'hF, {8'd2, 8'd5, 8'd3, 8'd0}, 1'b0);
    // R8 no qualifier
    apply("R8", 2'd2, {3'd2, 3'd3, 3'd2, 3'd3}, 4'h0, 4'hF, '0, 1'b0);
    apply("R8", 2'd1, {3'd4, 3'd4, 3'd4, 3'd4}, 4'h0, 4'hF, '0, 1'b1);

    // R10 random mix, results checked within the same cycle
    for (int i = 0; i < 600; i++) begin
      logic [3*NT-1:0] st;
      for (int t = 0; t < NT; t++) st[3*t +: 3] = 3'($urandom_range(0, 4));
      apply("R10", 2'($urandom_range(0, 3)), st, 4'($urandom), 4'($urandom),
            {8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
             8'($urandom_range(0, 3)), 8'($urandom_range(0, 3))},
            1'($urandom));
    end

    // R9 single-thread variant
    check1("R9", 3'd0, 1'b0, 1'b1);
    check1("R9", 3'd4, 1'b0, 1'b0);
    check1("R9", 3'd2, 1'b1, 1'b0);
    check1("R9", 3'd3, 1'b1, 1'b0);
    check1("R9", 3'd1, 1'b1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule